// File: doc/BRIEF.md
# Retirement-Qualified Tagged Event Counter

This block counts micro-operations that met a chosen performance event, but only those whose results become architectural. Each in-flight slot of the reorder window owns one mark bit. An allocation wipes the slot's mark. An event report sets the mark, and reporting the same event again for that slot changes nothing. When the slot retires, a per-op class bit says whether it lay on a cancelled path (bogus) or a committed one. Only a marked, committed op advances the counter, and it advances it by exactly one, however often the event hit that op.

A branch-recovery flush names the oldest cancelled slot. Every slot from that ID up to the allocation tail (the slot after the most recent allocation, wrapping around) loses its mark in that same cycle. A retirement into that range during the flush cycle counts as cancelled. When marking is switched off, the block counts every committed retirement. The counter has an enable that freezes it, saturates at its maximum, and shares a synchronous clear with the mark bits.

Top module: `retire_tag_counter`

## Requirements
- R1: While `tag_en`=1, a retirement with `ret_bogus`=0 of a slot whose mark is set raises `count_o` by one on the following clock edge.
- R2: A retirement with `ret_bogus`=1 never changes `count_o`.
- R3: Any number of event reports for one slot between its allocation and its retirement adds exactly one to `count_o` when it retires committed.
- R4: While `tag_en`=1, a committed retirement of an unmarked slot leaves `count_o` unchanged.
- R5: While `tag_en`=0, every retirement with `ret_bogus`=0 adds one, and event reports made in that mode set no mark.
- R6: Allocating a slot clears its mark. An allocation and an event report for the same slot in one cycle leave the mark clear.
- R7: A flush at ID F clears the marks of the slots F, F+1, ... up to but not including the tail, modulo 32, where the tail is one past the last allocated ID. It then sets the tail to F. Slots outside that range keep their marks. A retirement into the range in the flush cycle does not count.
- R8: An event report and a committed retirement for the same slot in one cycle count that retirement.
- R9: While `cnt_en`=0, `count_o` holds its value.
- R10: `count_o` saturates at 2^CNT_W-1. The default CNT_W is 40.
- R11: `cnt_clr`=1 zeroes `count_o`, all marks and the tail on the next edge, with priority over every other input.
- R12: After reset, `count_o` is 0 and all marks are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_en | input | 1 | 1: count marked ops; 0: count all committed ops |
| cnt_en | input | 1 | Counter advance enable |
| cnt_clr | input | 1 | Synchronous clear of counter, marks and tail |
| alloc_vld | input | 1 | Slot allocation strobe |
| alloc_id | input | SLOT_W | Allocated slot ID |
| evt_vld | input | 1 | Event report strobe |
| evt_id | input | SLOT_W | Slot that met the event |
| ret_vld | input | 1 | Retirement strobe |
| ret_id | input | SLOT_W | Retiring slot ID |
| ret_bogus | input | 1 | 1: retiring op was on a cancelled path |
| flush_vld | input | 1 | Flush strobe |
| flush_id | input | SLOT_W | Oldest cancelled slot |
| count_o | output | CNT_W | Retired-marked-op count |

## Verification
The hardest case to reach is a flush whose range wraps past slot 31 while marked slots lie on both sides of its boundaries. Whether a mark survived can only be seen through a later retirement. The stimulus therefore allocates a run that crosses the wrap point, marks every slot in it, flushes in the middle, and retires each slot one at a time. The per-slot count deltas then show the exact range that was cleared. Saturation is reached by building the bench with a narrow counter.

// File: rtl/retire_tag_pkg.sv
package retire_tag_pkg;

  // Forward distance from base to idx on a ring of 2**w slots
  function automatic logic [63:0] ring_dist(input logic [63:0] idx,
                                            input logic [63:0] base,
                                            input int w);
    logic [63:0] mask;
    mask = (64'd1 << w) - 64'd1;
    return (idx - base) & mask;
  endfunction

  // True when idx lies in the half-open ring window [base, tail)
  function automatic logic in_window(input logic [63:0] idx,
                                     input logic [63:0] base,
                                     input logic [63:0] tail,
                                     input int w);
    return ring_dist(idx, base, w) < ring_dist(tail, base, w);
  endfunction

endpackage

// File: rtl/rtc_tag_array.sv
module rtc_tag_array #(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tag_en,
  input  logic              alloc_vld,
  input  logic [SLOT_W-1:0] alloc_id,
  input  logic              evt_vld,
  input  logic [SLOT_W-1:0] evt_id,
  input  logic              ret_vld,
  input  logic [SLOT_W-1:0] ret_id,
  input  logic              flush_vld,
  input  logic [SLOT_W-1:0] flush_id,
  output logic              ret_tagged,
  output logic              ret_squashed,
  output logic [(1<<SLOT_W)-1:0] tags_o
);
  import retire_tag_pkg::*;
  localparam int NSLOT = 1 << SLOT_W;

  logic [SLOT_W-1:0] tail_q;
  logic [NSLOT-1:0]  tags_q;
  logic [NSLOT-1:0]  flush_hit;
  logic              evt_set;
  logic              flush_base_hit;

  // An event marks only when marking is on and no same-slot allocation wins
  assign evt_set = evt_vld && tag_en && !(alloc_vld && alloc_id == evt_id);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign flush_hit[i] = flush_vld &&
      in_window(64'(i), 64'(flush_id), 64'(tail_q), SLOT_W);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       tags_q[i] <= 1'b0;
      else if (clr)                                     tags_q[i] <= 1'b0;
      else if (flush_hit[i])                            tags_q[i] <= 1'b0;
      else if (alloc_vld && alloc_id == SLOT_W'(i))     tags_q[i] <= 1'b0;
      else if (evt_set && evt_id == SLOT_W'(i))         tags_q[i] <= 1'b1;
      else if (ret_vld && ret_id == SLOT_W'(i))         tags_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tail_q <= '0;
    else if (clr)        tail_q <= '0;
    else if (flush_vld)  tail_q <= flush_id;
    else if (alloc_vld)  tail_q <= alloc_id + SLOT_W'(1);
  end

  assign ret_tagged     = tags_q[ret_id] || (evt_set && evt_id == ret_id);
  assign ret_squashed   = flush_hit[ret_id];
  assign flush_base_hit = flush_hit[flush_id];
  assign tags_o         = tags_q;

  AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld |=> !tags_o[$past(alloc_id)]); // R6
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_base_hit |=> !tags_o[$past(flush_id)]); // R7
  AST_CLR_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> tags_o == '0); // R11
  AST_EVT_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set && !clr && !flush_hit[evt_id] && !(ret_vld && ret_id == evt_id))
      |=> tags_o[$past(evt_id)]); // R3
  AST_NO_MARK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!tag_en && evt_vld && !tags_o[evt_id]) |=> !tags_o[$past(evt_id)]); // R5
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             hit,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step = hit && en && (cnt_q != CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count_o = cnt_q;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + CNT_W'(1))); // R3
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(count_o)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_MAX && !clr) |=> count_o == CNT_MAX); // R10
  AST_CLR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count_o == '0); // R11
endmodule

// File: rtl/retire_tag_counter.sv
module retire_tag_counter #(
  parameter int SLOT_W = 5,
  parameter int CNT_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_en,
  input  logic              cnt_en,
  input  logic              cnt_clr,
  input  logic              alloc_vld,
  input  logic [SLOT_W-1:0] alloc_id,
  input  logic              evt_vld,
  input  logic [SLOT_W-1:0] evt_id,
  input  logic              ret_vld,
  input  logic [SLOT_W-1:0] ret_id,
  input  logic              ret_bogus,
  input  logic              flush_vld,
  input  logic [SLOT_W-1:0] flush_id,
  output logic [CNT_W-1:0]  count_o
);
  localparam int NSLOT = 1 << SLOT_W;

  logic             ret_tagged;
  logic             ret_squashed;
  logic             commit_hit;
  logic [NSLOT-1:0] tags;

  rtc_tag_array #(.SLOT_W(SLOT_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tag_en(tag_en),
    .alloc_vld(alloc_vld), .alloc_id(alloc_id),
    .evt_vld(evt_vld), .evt_id(evt_id),
    .ret_vld(ret_vld), .ret_id(ret_id),
    .flush_vld(flush_vld), .flush_id(flush_id),
    .ret_tagged(ret_tagged), .ret_squashed(ret_squashed), .tags_o(tags)
  );

  // Committed, not squashed, and marked (or marking off)
  assign commit_hit = ret_vld && !ret_bogus && !ret_squashed &&
                      (tag_en ? ret_tagged : 1'b1);

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
    .hit(commit_hit), .count_o(count_o)
  );

  AST_BOGUS_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && ret_bogus && !cnt_clr) |=> $stable(count_o)); // R2
  AST_SQUASH_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && ret_squashed && !cnt_clr) |=> $stable(count_o)); // R7
  AST_UNTAGGED_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && tag_en && !tags[ret_id] && !(evt_vld && evt_id == ret_id) && !cnt_clr)
      |=> $stable(count_o)); // R4
  AST_RESET_STATE: assert property (@(posedge clk)
    $rose(rst_n) |-> (count_o == '0 && tags == '0)); // R12
endmodule

// File: tb/test_retire_tag_counter.sv
module test_retire_tag_counter;
  localparam int SW = 5;
  localparam int CW = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tag_en = 1'b1, cnt_en = 1'b1, cnt_clr = 1'b0;
  logic alloc_vld = 1'b0, evt_vld = 1'b0, ret_vld = 1'b0, ret_bogus = 1'b0, flush_vld = 1'b0;
  logic [SW-1:0] alloc_id = '0, evt_id = '0, ret_id = '0, flush_id = '0;
  logic [CW-1:0] count_o;

  int tests = 0;
  int fails = 0;
  int base;
  int expd;

  always #2.5 clk = ~clk;

  retire_tag_counter #(.SLOT_W(SW), .CNT_W(CW)) i_retire_tag_counter (
    .clk(clk), .rst_n(rst_n), .tag_en(tag_en), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
    .alloc_vld(alloc_vld), .alloc_id(alloc_id), .evt_vld(evt_vld), .evt_id(evt_id),
    .ret_vld(ret_vld), .ret_id(ret_id), .ret_bogus(ret_bogus),
    .flush_vld(flush_vld), .flush_id(flush_id), .count_o(count_o));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: count=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    alloc_vld = 1'b0; evt_vld = 1'b0; ret_vld = 1'b0; flush_vld = 1'b0;
    cnt_clr = 1'b0; ret_bogus = 1'b0;
  endtask

  task automatic alloc(input int id);
    alloc_vld = 1'b1; alloc_id = SW'(id); tick();
  endtask
  task automatic evt(input int id);
    evt_vld = 1'b1; evt_id = SW'(id); tick();
  endtask
  task automatic retire(input int id, input logic bog);
    ret_vld = 1'b1; ret_id = SW'(id); ret_bogus = bog; tick();
  endtask
  task automatic clear();
    cnt_clr = 1'b1; tick();
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog: count=%0d expected=done", count_o);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #12;
    check("R12 reset", int'(count_o), 0);
    @(negedge clk); rst_n = 1'b1;
    tick();
    check("R12 after reset", int'(count_o), 0);

    // Sweep all slots: slot i gets i%3 events, is bogus when i%4==3
    expd = 0;
    for (int i = 0; i < 32; i++) begin
      alloc(i);
      for (int k = 0; k < i % 3; k++) evt(i);
      base = int'(count_o);
      retire(i, (i % 4) == 3);
      if ((i % 4) == 3)       check("R2 bogus", int'(count_o) - base, 0);
      else if ((i % 3) == 0)  check("R4 unmarked", int'(count_o) - base, 0);
      else if ((i % 3) == 2)  check("R3 repeat events", int'(count_o) - base, 1);
      else                    check("R1 marked commit", int'(count_o) - base, 1);
      if ((i % 4) != 3 && (i % 3) != 0) expd++;
    end
    check("R1 sweep total", int'(count_o), expd);

    // R11: clear wipes counter and marks
    alloc(3); evt(3);
    clear();
    check("R11 counter cleared", int'(count_o), 0);
    retire(3, 1'b0);
    check("R11 mark cleared", int'(count_o), 0);

    // R6: allocation wins over same-cycle event
    alloc(8); evt(8); alloc(8);
    retire(8, 1'b0);
    check("R6 realloc clears", int'(count_o), 0);
    alloc_vld = 1'b1; alloc_id = SW'(9); evt_vld = 1'b1; evt_id = SW'(9); tick();
    retire(9, 1'b0);
    check("R6 alloc beats event", int'(count_o), 0);

    // R8: event and retire same cycle
    alloc(10);
    evt_vld = 1'b1; evt_id = SW'(10); ret_vld = 1'b1; ret_id = SW'(10); tick();
    check("R8 same-cycle event", int'(count_o), 1);

    // R7: flush without wrap, slots 0..7, flush at 4
    clear();
    for (int i = 0; i < 8; i++) alloc(i);
    for (int i = 0; i < 8; i++) evt(i);
    flush_vld = 1'b1; flush_id = SW'(4); tick();
    for (int i = 0; i < 8; i++) begin
      base = int'(count_o);
      retire(i, 1'b0);
      check("R7 flush range", int'(count_o) - base, (i < 4) ? 1 : 0);
    end

    // R7: wrapping range, slots 28..31,0,1, flush at 30
    clear();
    for (int i = 28; i < 34; i++) alloc(i % 32);
    for (int i = 28; i < 34; i++) evt(i % 32);
    flush_vld = 1'b1; flush_id = SW'(30); tick();
    for (int i = 28; i < 34; i++) begin
      base = int'(count_o);
      retire(i % 32, 1'b0);
      check("R7 wrapped flush", int'(count_o) - base, (i < 30) ? 1 : 0);
    end

    // R7: retire into flush range in flush cycle
    clear();
    alloc(5); evt(5);
    flush_vld = 1'b1; flush_id = SW'(5); ret_vld = 1'b1; ret_id = SW'(5); tick();
    check("R7 retire in flush cycle", int'(count_o), 0);

    // R5: marking off
    clear();
    tag_en = 1'b0;
    alloc(2); evt(2);
    tag_en = 1'b1;
    retire(2, 1'b0);
    check("R5 event ignored when off", int'(count_o), 0);
    tag_en = 1'b0;
    retire(6, 1'b0);
    check("R5 plain commit counts", int'(count_o), 1);
    retire(6, 1'b1);
    check("R5 bogus still ignored", int'(count_o), 1);

    // R9: enable low holds
    tag_en = 1'b1; cnt_en = 1'b0;
    alloc(11); evt(11); retire(11, 1'b0);
    check("R9 hold while disabled", int'(count_o), 1);
    cnt_en = 1'b1;

    // R10: saturation with marking off
    clear();
    tag_en = 1'b0;
    for (int k = 1; k <= CMAX + 7; k++) begin
      retire(k % 32, 1'b0);
      if (k >= CMAX - 1) check("R10 saturate", int'(count_o), (k < CMAX) ? k : CMAX);
    end
    clear();
    check("R11 clear from max", int'(count_o), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule